// File: doc/BRIEF.md
# Compare-Triggered Conversion Start Controller

This block paces an external analog-to-digital converter from a free-running 16-bit timer. A 16-bit compare value and a 4-bit mode field decide when a trigger event happens. When the mode selects the trigger function and the timer equals the compare value, the event forces the timer back to zero, so the trigger repeats with a period of compare+1 cycles and no software help. If the converter is enabled and idle, the same event raises the busy (GO) bit, waits a programmed acquisition time, and then pulses a one-cycle start to the converter. When the converter reports done, the 10-bit result is justified into two byte-wide result registers, busy drops, and an interrupt flag is raised.

Software reaches every register through a simple byte-wide bus: a write strobe, an address and write data, with read data that follows the address combinationally. Software can also start a conversion by hand, or abort one by clearing the busy or enable bit. The control state machine has four states. IDLE waits for a trigger. ACQUIRE counts down the acquisition time. START drives the start pulse for one cycle. CONVERT waits for done. Its transitions are: IDLE to ACQUIRE (a trigger with a non-zero acquisition time), IDLE to START (a trigger with zero acquisition time), ACQUIRE to START (the count is exhausted), START to CONVERT (always), CONVERT to IDLE (done, which captures the result), and ACQUIRE, START or CONVERT to IDLE (abort).

Top module: `conv_trigger_ctrl`

## Requirements
- R1: Address map: 0 timer low byte, 1 timer high byte, 2 compare low, 3 compare high, 4 mode (bits [3:0]), 5 control A (channel bits [5:2], busy/GO bit 1, enable bit 0), 6 control B (justify bit 7, acquisition code bits [5:3], clock scale bits [2:0]), 7 result high, 8 result low, 9 flags (interrupt bit 0). After reset, addresses 2 to 9 read zero and `conv_start` and `conv_irq` are low.
- R2: The timer adds one every cycle and wraps. A write to address 0 loads the low byte and clears the high byte. A write to address 1 loads only the high byte.
- R3: The trigger function is active only when the mode field equals 4'b1011. With any other mode the timer runs past the compare value without being reset.
- R4: A trigger happens at the clock edge where the timer equals the compare value. That edge forces the timer to zero, and this takes priority over the increment and over a bus load of the timer.
- R5: A trigger with enable = 1 while the block is idle sets busy (address 5 bit 1) at the same edge and starts the acquisition. `conv_start` rises compare+1+N cycles after a timer load of zero, where N is the acquisition length.
- R6: A trigger with enable = 0 starts nothing, and busy stays 0. The timer is still reset.
- R7: N = P × 2^S cycles, where S is the clock scale field and P is taken from the acquisition code 0..7 as 0, 2, 4, 6, 8, 12, 16, 20.
- R8: `conv_start` is high for exactly one cycle per conversion.
- R9: `conv_done` in the CONVERT state latches `conv_data` at that edge and clears busy. With justify = 1 the high byte is {000000, d[9:8]} and the low byte is d[7:0]. With justify = 0 the high byte is d[9:2] and the low byte is {d[1:0], 000000}.
- R10: A trigger that arrives while busy does not restart or add a conversion, but it still resets the timer.
- R11: A write to address 5 whose bits [1:0] are not 2'b11 while busy aborts the conversion. A later `conv_done` changes neither the result registers nor the interrupt flag.
- R12: A write to address 5 with bits [1:0] = 2'b11 while idle starts a conversion as a trigger would. Bits [1:0] = 2'b10 start nothing.
- R13: The interrupt flag is set by each result capture and is driven on `conv_irq`. Writing address 9 with bit 0 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from the address |
| conv_chan | output | 4 | Selected analog channel |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | Converter finished |
| conv_data | input | 10 | Converter result, valid with conv_done |
| conv_irq | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench counts clock edges from the write that loads the timer with zero. `conv_start` must first be seen exactly compare+1+N cycles later, or N cycles later for a start written by software, where that write counts as the trigger. The timer reads after a trigger are made at a fixed edge count, so the reset value can be predicted exactly. Result bytes, busy and the interrupt flag must have changed at the edge that samples `conv_done`, so they are read at the falling edge right after the done pulse, with read data sampled combinationally from the address.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_START,
        ST_CONVERT
    } conv_state_e;

    localparam logic [3:0] MODE_TRIGGER = 4'b1011;

    localparam logic [3:0] A_TMR_LO = 4'd0;
    localparam logic [3:0] A_TMR_HI = 4'd1;
    localparam logic [3:0] A_CMP_LO = 4'd2;
    localparam logic [3:0] A_CMP_HI = 4'd3;
    localparam logic [3:0] A_MODE   = 4'd4;
    localparam logic [3:0] A_CTLA   = 4'd5;
    localparam logic [3:0] A_CTLB   = 4'd6;
    localparam logic [3:0] A_RES_HI = 4'd7;
    localparam logic [3:0] A_RES_LO = 4'd8;
    localparam logic [3:0] A_FLAGS  = 4'd9;

    localparam int PERIOD_W = 5;

    // acquisition length in conversion-clock periods for each code
    function automatic logic [PERIOD_W-1:0] acq_periods(input logic [2:0] code);
        logic [PERIOD_W-1:0] p;
        case (code)
            3'd0:    p = 5'd0;
            3'd1:    p = 5'd2;
            3'd2:    p = 5'd4;
            3'd3:    p = 5'd6;
            3'd4:    p = 5'd8;
            3'd5:    p = 5'd12;
            3'd6:    p = 5'd16;
            default: p = 5'd20;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cts_trig_timer.sv
module cts_trig_timer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [2*BYTE_W-1:0] cmp_val,
    input  logic              armed,
    output logic [2*BYTE_W-1:0] tmr,
    output logic              trig
);
    localparam int TMR_W = 2 * BYTE_W;

    assign trig = armed && (tmr == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (trig) begin
            tmr <= '0;
        end else if (load_lo) begin
            tmr <= {{BYTE_W{1'b0}}, wdata};
        end else if (load_hi) begin
            tmr <= {wdata, tmr[BYTE_W-1:0]};
        end else begin
            tmr <= tmr + TMR_W'(1);
        end
    end

    // R4
    trig_clears_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (tmr == '0));

endmodule

// File: rtl/cts_conv_fsm.sv
module cts_conv_fsm
    import cts_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             adon,
    input  logic             sw_go,
    input  logic             abort,
    input  logic [CNT_W-1:0] acq_len,
    input  logic             conv_done,
    output logic             busy,
    output logic             conv_start,
    output logic             capture
);
    conv_state_e      state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             go_req;

    assign go_req = (trig && adon) || sw_go;

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (go_req) begin
                    if (acq_len == '0) begin
                        state_d = ST_START;
                    end else begin
                        state_d = ST_ACQUIRE;
                        cnt_d   = acq_len;
                    end
                end
            end
            ST_ACQUIRE: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (cnt == CNT_W'(1)) begin
                    state_d = ST_START;
                end else begin
                    cnt_d = cnt - CNT_W'(1);
                end
            end
            ST_START: begin
                state_d = abort ? ST_IDLE : ST_CONVERT;
            end
            ST_CONVERT: begin
                if (abort || conv_done) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        conv_start = (state == ST_START);
        capture    = (state == ST_CONVERT) && conv_done && !abort;
    end

    // R8
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R6
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trig && !adon && !sw_go) |=> (state == ST_IDLE));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && trig && !conv_done && !abort) |=> (state == ST_CONVERT));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> !busy);

    // R9
    capture_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == ST_IDLE));

endmodule

// File: rtl/cts_result_fmt.sv
module cts_result_fmt #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              right_just,
    input  logic [RES_W-1:0]  raw,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] right_pair, left_pair;

    assign right_pair = {{PAD_W{1'b0}}, raw};
    assign left_pair  = {raw, {PAD_W{1'b0}}};

    always_comb begin
        if (right_just) begin
            hi = right_pair[PAIR_W-1:BYTE_W];
            lo = right_pair[BYTE_W-1:0];
        end else begin
            hi = left_pair[PAIR_W-1:BYTE_W];
            lo = left_pair[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/conv_trigger_ctrl.sv
module conv_trigger_ctrl
    import cts_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RES_W  = 10,
    parameter int ADDR_W = 4,
    parameter int CHS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [CHS_W-1:0]  conv_chan,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              conv_irq
);
    localparam int TMR_W   = 2 * BYTE_W;
    localparam int SCALE_W = 3;
    localparam int CNT_W   = PERIOD_W + (1 << SCALE_W) - 1;

    logic [TMR_W-1:0]   r_cmp, tmr;
    logic [3:0]         r_mode;
    logic [CHS_W-1:0]   r_chs;
    logic               r_adon, r_adfm, r_irq;
    logic [2:0]         r_acqt;
    logic [SCALE_W-1:0] r_adcs;
    logic [BYTE_W-1:0]  r_res_hi, r_res_lo, fmt_hi, fmt_lo;
    logic [CNT_W-1:0]   acq_len;
    logic               trig, busy, capture, sw_go, abort, wr_ctla;

    assign wr_ctla = bus_we && (bus_addr == ADDR_W'(A_CTLA));
    assign sw_go   = wr_ctla && (bus_wdata[1:0] == 2'b11);
    assign abort   = wr_ctla && (bus_wdata[1:0] != 2'b11);
    assign acq_len = CNT_W'(acq_periods(r_acqt)) << r_adcs;

    cts_trig_timer #(.BYTE_W(BYTE_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (bus_we && (bus_addr == ADDR_W'(A_TMR_LO))),
        .load_hi (bus_we && (bus_addr == ADDR_W'(A_TMR_HI))),
        .wdata   (bus_wdata),
        .cmp_val (r_cmp),
        .armed   (r_mode == MODE_TRIGGER),
        .tmr     (tmr),
        .trig    (trig)
    );

    cts_conv_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .adon       (r_adon),
        .sw_go      (sw_go),
        .abort      (abort),
        .acq_len    (acq_len),
        .conv_done  (conv_done),
        .busy       (busy),
        .conv_start (conv_start),
        .capture    (capture)
    );

    cts_result_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) fmt_i (
        .right_just (r_adfm),
        .raw        (conv_data),
        .hi         (fmt_hi),
        .lo         (fmt_lo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_cmp  <= '0;
            r_mode <= '0;
            r_chs  <= '0;
            r_adon <= 1'b0;
            r_adfm <= 1'b0;
            r_acqt <= '0;
            r_adcs <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADDR_W'(A_CMP_LO): r_cmp[BYTE_W-1:0]     <= bus_wdata;
                ADDR_W'(A_CMP_HI): r_cmp[TMR_W-1:BYTE_W] <= bus_wdata;
                ADDR_W'(A_MODE):   r_mode <= bus_wdata[3:0];
                ADDR_W'(A_CTLA): begin
                    r_chs  <= bus_wdata[2+CHS_W-1:2];
                    r_adon <= bus_wdata[0];
                end
                ADDR_W'(A_CTLB): begin
                    r_adfm <= bus_wdata[7];
                    r_acqt <= bus_wdata[5:3];
                    r_adcs <= bus_wdata[SCALE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_res_hi <= '0;
            r_res_lo <= '0;
            r_irq    <= 1'b0;
        end else if (capture) begin
            r_res_hi <= fmt_hi;
            r_res_lo <= fmt_lo;
            r_irq    <= 1'b1;
        end else if (bus_we && bus_addr == ADDR_W'(A_FLAGS) && bus_wdata[0]) begin
            r_irq <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(A_TMR_LO): bus_rdata = tmr[BYTE_W-1:0];
            ADDR_W'(A_TMR_HI): bus_rdata = tmr[TMR_W-1:BYTE_W];
            ADDR_W'(A_CMP_LO): bus_rdata = r_cmp[BYTE_W-1:0];
            ADDR_W'(A_CMP_HI): bus_rdata = r_cmp[TMR_W-1:BYTE_W];
            ADDR_W'(A_MODE):   bus_rdata = BYTE_W'(r_mode);
            ADDR_W'(A_CTLA):   bus_rdata = BYTE_W'({r_chs, busy, r_adon});
            ADDR_W'(A_CTLB):   bus_rdata = {r_adfm, 1'b0, r_acqt, r_adcs};
            ADDR_W'(A_RES_HI): bus_rdata = r_res_hi;
            ADDR_W'(A_RES_LO): bus_rdata = r_res_lo;
            ADDR_W'(A_FLAGS):  bus_rdata = BYTE_W'(r_irq);
            default:           bus_rdata = '0;
        endcase
    end

    assign conv_chan = r_chs;
    assign conv_irq  = r_irq;

    // R13
    capture_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> conv_irq);

    // R11
    abort_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_done) |=> $stable(r_res_hi) && $stable(r_res_lo));

endmodule

// File: tb/conv_trigger_ctrl_tb_top.sv
module conv_trigger_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] conv_chan;
    logic       conv_start;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       conv_irq;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_trigger_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .conv_irq(conv_irq)
    );

    localparam int NV = 6;
    localparam int V_CMP  [NV] = '{20, 30, 15, 40, 25, 12};
    localparam int V_ACQT [NV] = '{0, 1, 7, 1, 5, 3};
    localparam int V_ADCS [NV] = '{0, 0, 0, 1, 0, 2};
    localparam int V_ADFM [NV] = '{1, 0, 1, 0, 1, 0};
    localparam int V_RES  [NV] = '{'h3FF, 'h2A5, 'h155, 'h003, 'h200, 'h0F0};
    localparam int V_DLY  [NV] = '{21, 33, 36, 45, 38, 37};
    localparam int V_HI   [NV] = '{'h03, 'hA9, 'h01, 'h00, 'h02, 'h3C};
    localparam int V_LO   [NV] = '{'hFF, 'h40, 'h55, 'hC0, 'h00, 'h00};

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_start(input int lim, output int seen);
        seen = 0;
        for (int k = 0; k < lim; k++) begin
            if (conv_start) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_done(input logic [9:0] d);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, cw, seen, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 2; a <= 9; a++) begin
            rd(4'(a), v);
            check("R1 reset reg", v, 0);
        end
        check("R1 start low", int'(conv_start), 0);
        check("R1 irq low", int'(conv_irq), 0);

        // R2: timer load and count
        wr(4'd1, 8'h12);
        wr(4'd0, 8'h10);
        rd(4'd0, v);
        check("R2 timer low load", v, 'h10);
        rd(4'd1, v);
        check("R2 low load clears high", v, 0);
        repeat (5) @(negedge clk);
        rd(4'd0, v);
        check("R2 timer counts", v, 'h15);

        // vector table: R5 R7 R8 R9 R13
        for (int i = 0; i < NV; i++) begin
            wr(4'd4, 8'h00);
            wr(4'd5, 8'h00);
            wr(4'd9, 8'h01);
            wr(4'd6, 8'((V_ADFM[i] << 7) | (V_ACQT[i] << 3) | V_ADCS[i]));
            wr(4'd2, 8'(V_CMP[i]));
            wr(4'd3, 8'h00);
            wr(4'd5, 8'h01);
            wr(4'd0, 8'h00);
            cw = cyc;
            wr(4'd4, 8'h0B);
            wait_start(200, seen);
            check("R5 start seen", seen, 1);
            check("R7 start delay", cyc - cw, V_DLY[i]);
            rd(4'd5, v);
            check("R5 busy set", (v >> 1) & 1, 1);
            @(negedge clk);
            check("R8 start one cycle", int'(conv_start), 0);
            @(negedge clk);
            pulse_done(10'(V_RES[i]));
            rd(4'd7, v);
            check("R9 result high", v, V_HI[i]);
            rd(4'd8, v);
            check("R9 result low", v, V_LO[i]);
            rd(4'd5, v);
            check("R9 busy cleared", (v >> 1) & 1, 0);
            check("R13 irq set", int'(conv_irq), 1);
        end

        // R3: other mode does not reset timer
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h00);
        wr(4'd9, 8'h01);
        wr(4'd2, 8'd20);
        wr(4'd5, 8'h01);
        wr(4'd0, 8'h00);
        cw = cyc;
        wr(4'd4, 8'h0A);
        n = 0;
        while (cyc < cw + 24) begin
            if (conv_start) n++;
            @(negedge clk);
        end
        rd(4'd0, v);
        check("R3 timer not reset", v, 24);
        check("R3 no start", n, 0);

        // R6: disabled converter, timer still resets
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h00);
        wr(4'd0, 8'h00);
        cw = cyc;
        wr(4'd4, 8'h0B);
        n = 0;
        while (cyc < cw + 24) begin
            if (conv_start) n++;
            @(negedge clk);
        end
        rd(4'd0, v);
        check("R6 timer reset when disabled", v, 3);
        check("R6 no start", n, 0);
        rd(4'd5, v);
        check("R6 busy clear", (v >> 1) & 1, 0);

        // R10: trigger while busy, then R11 abort
        wr(4'd4, 8'h00);
        wr(4'd6, 8'h80);
        wr(4'd9, 8'h01);
        wr(4'd5, 8'h01);
        wr(4'd0, 8'h00);
        cw = cyc;
        wr(4'd4, 8'h0B);
        wait_start(200, seen);
        check("R10 first start", cyc - cw, 21);
        @(negedge clk);
        n = 0;
        while (cyc < cw + 51) begin
            if (conv_start) n++;
            @(negedge clk);
        end
        check("R10 no second start", n, 0);
        rd(4'd0, v);
        check("R10 timer still reset", v, 9);
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h01);
        rd(4'd5, v);
        check("R11 abort clears busy", (v >> 1) & 1, 0);
        pulse_done(10'h3FF);
        rd(4'd7, v);
        check("R11 result high kept", v, 'h3C);
        rd(4'd8, v);
        check("R11 result low kept", v, 0);
        check("R11 no irq", int'(conv_irq), 0);

        // R12: software start
        wr(4'd6, 8'h00);
        wr(4'd5, 8'h03);
        cw = cyc;
        wait_start(20, seen);
        check("R12 sw start delay", cyc - cw, 0);
        @(negedge clk);
        pulse_done(10'h001);
        rd(4'd7, v);
        check("R12 result high", v, 0);
        rd(4'd8, v);
        check("R12 result low", v, 'h40);
        check("R13 irq after sw conversion", int'(conv_irq), 1);
        wr(4'd9, 8'h01);
        check("R13 irq cleared", int'(conv_irq), 0);
        wr(4'd5, 8'h02);
        wait_start(10, seen);
        check("R12 go without enable", seen, 0);

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule